// File: doc/BRIEF.md
# BX/DX Flag Arithmetic Unit

This unit owns two 16-bit working registers, BX and DX, and two status bits, a carry flag and an overflow flag. Each clock cycle it executes one operation selected by a 5-bit code. AX, LX and MA are read-only inputs, and CX is read only for a nonzero test. The operation set covers register moves and exchange, plain and carry-chained addition, borrow-chained subtraction, rotates through carry, a combined opposite-direction shift for multiply and divide loops, sign stripping and re-application around an unsigned multiply, absolute value, and a family of carry-setting tests used by conditional branches.

All state changes at the rising clock edge, and the outputs are the register values themselves. Multi-word subtraction expects the carry flag to be cleared before the lowest word is processed. Carry then carries a borrow (1 = borrow) from word to word.

Top module: `bxdx_flag_alu`

## Requirements
- R1: During and right after an active-low reset, BX, DX, carry and overflow all read 0.
- R2: Opcode 0 changes nothing. An operation changes carry or overflow only where its own requirement names that flag; every other operation leaves both flags as they were.
- R3: Data moves: op 1 DX=LX, op 2 DX=AX, op 3 DX=BX, op 4 DX=DX+AX, op 5 BX=AX+DX, op 6 BX=LX, op 7 BX=AX, op 8 BX=DX, op 9 BX=MA, op 10 swaps BX and DX, op 11 BX=0-BX, op 12 BX=carry (0 or 1). All sums wrap modulo 2^16.
- R4: Op 19 sets BX=BX+LX and op 20 sets BX=BX+AX+carry. Both write the carry out of bit 15 to carry. Both set overflow exactly when the signed result falls outside -32768..32767.
- R5: Op 21 sets BX=BX-AX-carry. Carry becomes 1 exactly when the unsigned difference is negative (a borrow). Overflow is set exactly when the signed difference falls outside -32768..32767.
- R6: Op 14 replaces BX with its magnitude if BX bit 15 is set, and does the same for DX in the same cycle. Overflow becomes the xor of the two original bit-15 values.
- R7: Op 15 negates BX only when overflow is 1 and otherwise leaves BX unchanged.
- R8: Op 16 shifts DX right by one with a 0 into bit 15. In the same cycle it shifts BX left by one with a 0 into bit 0, and the old BX bit 15 goes to carry.
- R9: Op 17 rotates BX right through carry: the old carry enters bit 15 and bit 0 goes to carry. Op 18 rotates left through carry: the old carry enters bit 0 and bit 15 goes to carry.
- R10: Op 22 negates BX if its bit 15 is set and copies the original bit 15 into carry.
- R11: Carry tests: op 27 carry=(DX!=0), op 28 carry=(BX==0), op 29 carry=(CX!=0), op 30 carry=BX bit 15, op 31 carry=BX bit 15 xor overflow.
- R12: Carry edits: op 23 clears carry, op 24 copies overflow into carry, op 25 inverts carry, op 13 sets carry=(AX!=0) AND carry.
- R13: Op 26 copies AX into DX when carry is 1 and leaves DX unchanged when carry is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 5 | Operation code for this cycle |
| ax | input | 16 | Read-only AX operand |
| lx | input | 16 | Read-only LX operand |
| ma | input | 16 | Read-only memory-address operand |
| cx | input | 16 | Read-only loop-counter operand for the nonzero test |
| bx | output | 16 | BX register |
| dx | output | 16 | DX register |
| cf | output | 1 | Carry flag |
| vf | output | 1 | Overflow flag |

## Verification
Operands are drawn either uniformly or from the set 0, 1, 0x7FFF, 0x8000 and 0xFFFF. The edge values drive the adder into signed overflow, unsigned carry and borrow, which separates a correct overflow rule from one that only looks at the sign bits. Directed steps clear carry before a subtract and then chain a second borrow word. They also pair a negative BX with a positive DX, and the reverse, for sign stripping. Each of these tells apart the xor-of-signs overflow, the incoming carry and the borrow polarity. Random opcode sequences keep the flags live from one operation to the next, so an operation that disturbs a flag it should not touch shows up in later carry tests and conditional moves.

// File: rtl/bxdx_pkg.sv
package bxdx_pkg;

  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP        = 5'd0,
    OP_DX_GETS_LX = 5'd1,
    OP_DX_GETS_AX = 5'd2,
    OP_DX_GETS_BX = 5'd3,
    OP_DX_ACC_AX  = 5'd4,
    OP_BX_GETS_AD = 5'd5,
    OP_BX_GETS_LX = 5'd6,
    OP_BX_GETS_AX = 5'd7,
    OP_BX_GETS_DX = 5'd8,
    OP_BX_GETS_MA = 5'd9,
    OP_SWAP_BD    = 5'd10,
    OP_BX_NEGATE  = 5'd11,
    OP_BX_GETS_CF = 5'd12,
    OP_CF_AND_AX  = 5'd13,
    OP_SIGN_STRIP = 5'd14,
    OP_SIGN_FIX   = 5'd15,
    OP_DUAL_SHIFT = 5'd16,
    OP_ROT_RIGHT  = 5'd17,
    OP_ROT_LEFT   = 5'd18,
    OP_ADD_LX     = 5'd19,
    OP_ADC_AX     = 5'd20,
    OP_SBC_AX     = 5'd21,
    OP_ABS_BX     = 5'd22,
    OP_CF_CLEAR   = 5'd23,
    OP_CF_FROM_VF = 5'd24,
    OP_CF_INVERT  = 5'd25,
    OP_CMOV_DX    = 5'd26,
    OP_T_DX_NZ    = 5'd27,
    OP_T_BX_ZERO  = 5'd28,
    OP_T_CX_NZ    = 5'd29,
    OP_T_BX_NEG   = 5'd30,
    OP_T_SIGNED_LT= 5'd31
  } bxop_e;

  typedef enum logic [1:0] {
    ADDER_BX_LX = 2'd0,
    ADDER_BX_AX = 2'd1,
    ADDER_IDLE  = 2'd2
  } adder_src_e;

endpackage

// File: rtl/bxdx_addsub.sv
module bxdx_addsub #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         carry_in,
  input  logic         subtract,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         ovf_out
);

  localparam int unsigned MSB = W - 1;

  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [W:0]   raw_sum;

  // Subtraction folds into addition: a - b - borrow = a + ~b + ~borrow.
  function automatic logic [W:0] wide_add(input logic [W-1:0] x,
                                          input logic [W-1:0] y,
                                          input logic         ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  always_comb begin
    b_eff   = subtract ? ~b_in : b_in;
    c_eff   = subtract ? ~carry_in : carry_in;
    raw_sum = wide_add(a_in, b_eff, c_eff);
    result  = raw_sum[W-1:0];
    // The flag holds a borrow when subtracting, hence the inversion.
    carry_out = subtract ? ~raw_sum[W] : raw_sum[W];
    // Signed overflow: both effective operands agree in sign, the result does not.
    ovf_out = (a_in[MSB] == b_eff[MSB]) && (raw_sum[MSB] != a_in[MSB]);
  end

endmodule

// File: rtl/bxdx_shifter.sv
module bxdx_shifter #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] bx_q,
  input  logic [W-1:0] dx_q,
  input  logic         cf_q,
  input  logic         vf_q,
  output logic [W-1:0] ror_bx,
  output logic         ror_cf,
  output logic [W-1:0] rol_bx,
  output logic         rol_cf,
  output logic [W-1:0] dsh_bx,
  output logic [W-1:0] dsh_dx,
  output logic         dsh_cf,
  output logic [W-1:0] strip_bx,
  output logic [W-1:0] strip_dx,
  output logic         strip_vf,
  output logic [W-1:0] fix_bx,
  output logic [W-1:0] abs_bx,
  output logic         abs_cf,
  output logic [W-1:0] neg_bx
);

  localparam int unsigned MSB = W - 1;

  function automatic logic [W-1:0] twos_neg(input logic [W-1:0] v);
    return (~v) + {{(W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v);
    return v[MSB] ? twos_neg(v) : v;
  endfunction

  always_comb begin
    neg_bx   = twos_neg(bx_q);
    // Rotates through the carry flag.
    ror_bx   = {cf_q, bx_q[MSB:1]};
    ror_cf   = bx_q[0];
    rol_bx   = {bx_q[MSB-1:0], cf_q};
    rol_cf   = bx_q[MSB];
    // Opposite-direction shift pair for shift-and-add loops.
    dsh_dx   = {1'b0, dx_q[MSB:1]};
    dsh_bx   = {bx_q[MSB-1:0], 1'b0};
    dsh_cf   = bx_q[MSB];
    // Sign handling around an unsigned multiply.
    strip_bx = magnitude(bx_q);
    strip_dx = magnitude(dx_q);
    strip_vf = bx_q[MSB] ^ dx_q[MSB];
    fix_bx   = vf_q ? twos_neg(bx_q) : bx_q;
    abs_bx   = magnitude(bx_q);
    abs_cf   = bx_q[MSB];
  end

endmodule

// File: rtl/bxdx_cond.sv
module bxdx_cond #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] ax_in,
  input  logic [W-1:0] bx_q,
  input  logic [W-1:0] dx_q,
  input  logic [W-1:0] cx_in,
  input  logic         cf_q,
  input  logic         vf_q,
  output logic         bx_is_zero,
  output logic         dx_nonzero,
  output logic         cx_nonzero,
  output logic         bx_negative,
  output logic         signed_less,
  output logic         ax_and_cf
);

  always_comb begin
    bx_is_zero  = (bx_q == '0);
    dx_nonzero  = |dx_q;
    cx_nonzero  = |cx_in;
    bx_negative = bx_q[W-1];
    // After BX - AX, sign xor overflow gives the true signed comparison.
    signed_less = bx_q[W-1] ^ vf_q;
    ax_and_cf   = (|ax_in) & cf_q;
  end

endmodule

// File: rtl/bxdx_flag_alu.sv
module bxdx_flag_alu
  import bxdx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] ax,
  input  logic [DATA_W-1:0] lx,
  input  logic [DATA_W-1:0] ma,
  input  logic [DATA_W-1:0] cx,
  output logic [DATA_W-1:0] bx,
  output logic [DATA_W-1:0] dx,
  output logic              cf,
  output logic              vf
);

  localparam int unsigned MSB = DATA_W - 1;

  bxop_e opc;
  assign opc = bxop_e'(op);

  // Adder operand selection.
  adder_src_e        add_src;
  logic [DATA_W-1:0] add_b;
  logic              add_cin;
  logic              add_sub;
  logic [DATA_W-1:0] add_res;
  logic              add_cout;
  logic              add_ovf;

  always_comb begin
    unique case (opc)
      OP_ADD_LX:             add_src = ADDER_BX_LX;
      OP_ADC_AX, OP_SBC_AX:  add_src = ADDER_BX_AX;
      default:               add_src = ADDER_IDLE;
    endcase
    add_b   = (add_src == ADDER_BX_LX) ? lx : ax;
    add_cin = (add_src == ADDER_BX_LX) ? 1'b0 : cf;
    add_sub = (opc == OP_SBC_AX);
  end

  bxdx_addsub #(.W(DATA_W)) u_addsub (
    .a_in     (bx),
    .b_in     (add_b),
    .carry_in (add_cin),
    .subtract (add_sub),
    .result   (add_res),
    .carry_out(add_cout),
    .ovf_out  (add_ovf)
  );

  logic [DATA_W-1:0] ror_bx, rol_bx, dsh_bx, dsh_dx;
  logic [DATA_W-1:0] strip_bx, strip_dx, fix_bx, abs_bx, neg_bx;
  logic              ror_cf, rol_cf, dsh_cf, strip_vf, abs_cf;

  bxdx_shifter #(.W(DATA_W)) u_shifter (
    .bx_q    (bx),
    .dx_q    (dx),
    .cf_q    (cf),
    .vf_q    (vf),
    .ror_bx  (ror_bx),
    .ror_cf  (ror_cf),
    .rol_bx  (rol_bx),
    .rol_cf  (rol_cf),
    .dsh_bx  (dsh_bx),
    .dsh_dx  (dsh_dx),
    .dsh_cf  (dsh_cf),
    .strip_bx(strip_bx),
    .strip_dx(strip_dx),
    .strip_vf(strip_vf),
    .fix_bx  (fix_bx),
    .abs_bx  (abs_bx),
    .abs_cf  (abs_cf),
    .neg_bx  (neg_bx)
  );

  logic t_bx_zero, t_dx_nz, t_cx_nz, t_bx_neg, t_slt, t_and;

  bxdx_cond #(.W(DATA_W)) u_cond (
    .ax_in      (ax),
    .bx_q       (bx),
    .dx_q       (dx),
    .cx_in      (cx),
    .cf_q       (cf),
    .vf_q       (vf),
    .bx_is_zero (t_bx_zero),
    .dx_nonzero (t_dx_nz),
    .cx_nonzero (t_cx_nz),
    .bx_negative(t_bx_neg),
    .signed_less(t_slt),
    .ax_and_cf  (t_and)
  );

  // Named next-state wires.
  logic [DATA_W-1:0] bx_next, dx_next;
  logic              cf_next, vf_next;
  logic              cf_touch, vf_touch;

  always_comb begin
    bx_next  = bx;
    dx_next  = dx;
    cf_next  = cf;
    vf_next  = vf;
    unique case (opc)
      OP_NOP:         ;
      OP_DX_GETS_LX:  dx_next = lx;
      OP_DX_GETS_AX:  dx_next = ax;
      OP_DX_GETS_BX:  dx_next = bx;
      OP_DX_ACC_AX:   dx_next = dx + ax;
      OP_BX_GETS_AD:  bx_next = ax + dx;
      OP_BX_GETS_LX:  bx_next = lx;
      OP_BX_GETS_AX:  bx_next = ax;
      OP_BX_GETS_DX:  bx_next = dx;
      OP_BX_GETS_MA:  bx_next = ma;
      OP_SWAP_BD: begin
        bx_next = dx;
        dx_next = bx;
      end
      OP_BX_NEGATE:   bx_next = neg_bx;
      OP_BX_GETS_CF:  bx_next = {{(DATA_W-1){1'b0}}, cf};
      OP_CF_AND_AX:   cf_next = t_and;
      OP_SIGN_STRIP: begin
        bx_next = strip_bx;
        dx_next = strip_dx;
        vf_next = strip_vf;
      end
      OP_SIGN_FIX:    bx_next = fix_bx;
      OP_DUAL_SHIFT: begin
        bx_next = dsh_bx;
        dx_next = dsh_dx;
        cf_next = dsh_cf;
      end
      OP_ROT_RIGHT: begin
        bx_next = ror_bx;
        cf_next = ror_cf;
      end
      OP_ROT_LEFT: begin
        bx_next = rol_bx;
        cf_next = rol_cf;
      end
      OP_ADD_LX, OP_ADC_AX, OP_SBC_AX: begin
        bx_next = add_res;
        cf_next = add_cout;
        vf_next = add_ovf;
      end
      OP_ABS_BX: begin
        bx_next = abs_bx;
        cf_next = abs_cf;
      end
      OP_CF_CLEAR:    cf_next = 1'b0;
      OP_CF_FROM_VF:  cf_next = vf;
      OP_CF_INVERT:   cf_next = ~cf;
      OP_CMOV_DX:     if (cf) dx_next = ax;
      OP_T_DX_NZ:     cf_next = t_dx_nz;
      OP_T_BX_ZERO:   cf_next = t_bx_zero;
      OP_T_CX_NZ:     cf_next = t_cx_nz;
      OP_T_BX_NEG:    cf_next = t_bx_neg;
      OP_T_SIGNED_LT: cf_next = t_slt;
      default:        ;
    endcase
  end

  // Which operations are allowed to write each flag.
  always_comb begin
    cf_touch = 1'b0;
    vf_touch = 1'b0;
    unique case (opc)
      OP_CF_AND_AX, OP_DUAL_SHIFT, OP_ROT_RIGHT, OP_ROT_LEFT, OP_ABS_BX,
      OP_CF_CLEAR, OP_CF_FROM_VF, OP_CF_INVERT, OP_T_DX_NZ, OP_T_BX_ZERO,
      OP_T_CX_NZ, OP_T_BX_NEG, OP_T_SIGNED_LT: cf_touch = 1'b1;
      OP_ADD_LX, OP_ADC_AX, OP_SBC_AX: begin
        cf_touch = 1'b1;
        vf_touch = 1'b1;
      end
      OP_SIGN_STRIP: vf_touch = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bx <= '0;
      dx <= '0;
      cf <= 1'b0;
      vf <= 1'b0;
    end else begin
      bx <= bx_next;
      dx <= dx_next;
      cf <= cf_touch ? cf_next : cf;
      vf <= vf_touch ? vf_next : vf;
    end
  end

  // R2
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP) |=> ($stable(bx) && $stable(dx) && $stable(cf) && $stable(vf)));

  // R2
  flag_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op inside {[OP_DX_GETS_LX:OP_BX_GETS_CF], OP_SIGN_FIX, OP_CMOV_DX})
      |=> ($stable(cf) && $stable(vf)));

  // R5
  sbc_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SBC_AX) |=>
      (cf == ({1'b0, $past(bx)} < ({1'b0, $past(ax)} + {{DATA_W{1'b0}}, $past(cf)}))));

  // R7
  sign_fix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SIGN_FIX && !vf) |=> $stable(bx));

  // R9
  rol_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROT_LEFT) |=> (bx[0] == $past(cf) && cf == $past(bx[MSB])));

  // R8
  dual_shift_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DUAL_SHIFT) |=> (!dx[MSB] && !bx[0] && cf == $past(bx[MSB])));

  // R11
  signed_less_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_T_SIGNED_LT) |=> (cf == ($past(bx[MSB]) ^ $past(vf))));

  // R13
  cmov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMOV_DX && !cf) |=> $stable(dx));

  // R6
  strip_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SIGN_STRIP && !bx[MSB] && !dx[MSB]) |=> ($stable(bx) && $stable(dx) && !vf));

endmodule

// File: tb/bxdx_flag_alu_bench.sv
module bxdx_flag_alu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op = 5'd0;
  logic [15:0] ax = '0, lx = '0, ma = '0, cx = '0;
  logic [15:0] bx, dx;
  logic        cf, vf;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  // model state
  logic [15:0] m_bx = '0, m_dx = '0;
  logic        m_cf = 1'b0, m_vf = 1'b0;

  always #10 clk = ~clk;

  bxdx_flag_alu u_bxdx_flag_alu (
    .clk(clk), .rst_n(rst_n), .op(op), .ax(ax), .lx(lx), .ma(ma), .cx(cx),
    .bx(bx), .dx(dx), .cf(cf), .vf(vf)
  );

  function automatic string req_of(input int o);
    if (o == 0) return "R2";
    if (o <= 12) return "R3";
    if (o == 13) return "R12";
    if (o == 14) return "R6";
    if (o == 15) return "R7";
    if (o == 16) return "R8";
    if (o == 17 || o == 18) return "R9";
    if (o == 19 || o == 20) return "R4";
    if (o == 21) return "R5";
    if (o == 22) return "R10";
    if (o >= 23 && o <= 25) return "R12";
    if (o == 26) return "R13";
    return "R11";
  endfunction

  function automatic logic [15:0] neg16(input logic [15:0] v);
    return 16'(0 - int'(v));
  endfunction

  // Reference: signed/unsigned integer arithmetic, independent of any adder form.
  task automatic model_step(input int o, input logic [15:0] a, l, m, c);
    int s, u;
    logic [15:0] b0 = m_bx, d0 = m_dx;
    logic c0 = m_cf, v0 = m_vf;
    case (o)
      1:  m_dx = l;
      2:  m_dx = a;
      3:  m_dx = b0;
      4:  m_dx = 16'(int'(d0) + int'(a));
      5:  m_bx = 16'(int'(a) + int'(d0));
      6:  m_bx = l;
      7:  m_bx = a;
      8:  m_bx = d0;
      9:  m_bx = m;
      10: begin m_bx = d0; m_dx = b0; end
      11: m_bx = neg16(b0);
      12: m_bx = c0 ? 16'd1 : 16'd0;
      13: m_cf = (a != 0) && c0;
      14: begin
        m_bx = b0[15] ? neg16(b0) : b0;
        m_dx = d0[15] ? neg16(d0) : d0;
        m_vf = b0[15] != d0[15];
      end
      15: if (v0) m_bx = neg16(b0);
      16: begin m_dx = d0 >> 1; m_bx = b0 << 1; m_cf = b0[15]; end
      17: begin m_bx = (b0 >> 1) | (c0 ? 16'h8000 : 16'h0); m_cf = b0[0]; end
      18: begin m_bx = (b0 << 1) | {15'd0, c0}; m_cf = b0[15]; end
      19, 20: begin
        logic [15:0] rhs = (o == 19) ? l : a;
        int ci = (o == 20 && c0) ? 1 : 0;
        u = int'(b0) + int'(rhs) + ci;
        s = int'($signed(b0)) + int'($signed(rhs)) + ci;
        m_bx = 16'(u);
        m_cf = u > 65535;
        m_vf = (s > 32767) || (s < -32768);
      end
      21: begin
        int ci = c0 ? 1 : 0;
        u = int'(b0) - int'(a) - ci;
        s = int'($signed(b0)) - int'($signed(a)) - ci;
        m_bx = 16'(u);
        m_cf = u < 0;
        m_vf = (s > 32767) || (s < -32768);
      end
      22: begin m_bx = b0[15] ? neg16(b0) : b0; m_cf = b0[15]; end
      23: m_cf = 1'b0;
      24: m_cf = v0;
      25: m_cf = !c0;
      26: if (c0) m_dx = a;
      27: m_cf = d0 != 0;
      28: m_cf = b0 == 0;
      29: m_cf = c != 0;
      30: m_cf = b0[15];
      31: m_cf = b0[15] != v0;
      default: ;
    endcase
  endtask

  task automatic apply(input int o, input logic [15:0] a, l, m, c);
    op = 5'(o); ax = a; lx = l; ma = m; cx = c;
    model_step(o, a, l, m, c);
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (bx !== m_bx || dx !== m_dx || cf !== m_cf || vf !== m_vf) begin
      n_bad++;
      $display("FAIL %s op=%0d actual bx=%h dx=%h cf=%b vf=%b expected bx=%h dx=%h cf=%b vf=%b",
               req_of(o), o, bx, dx, cf, vf, m_bx, m_dx, m_cf, m_vf);
    end
  endtask

  function automatic logic [15:0] pick();
    logic [15:0] edges [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
    if (($urandom % 4) == 0) return edges[$urandom % 5];
    return 16'($urandom);
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd20531);
    repeat (3) @(negedge clk);
    // R1: reset values, held while reset is active
    n_vec++;
    if (bx !== 16'h0 || dx !== 16'h0 || cf !== 1'b0 || vf !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 actual bx=%h dx=%h cf=%b vf=%b expected 0 0 0 0", bx, dx, cf, vf);
    end
    rst_n = 1'b1;

    // R2: opcode 0 after loading nonzero state
    apply(7, 16'h1234, 0, 0, 0);
    apply(2, 16'h8001, 0, 0, 0);
    apply(25, 0, 0, 0, 0);
    apply(0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    // R3: each move once
    for (int o = 1; o <= 12; o++) apply(o, 16'h0F0F + 16'(o), 16'hA5A5, 16'h3C3C, 0);
    // R5: cleared carry, then signed overflow
    apply(23, 0, 0, 0, 0);
    apply(7, 16'h8000, 0, 0, 0);
    apply(21, 16'h0001, 0, 0, 0);          // 0x7FFF, vf=1, cf=0
    apply(31, 0, 0, 0, 0);                 // R11 signed less after subtract
    apply(7, 16'h0000, 0, 0, 0);
    apply(21, 16'h0001, 0, 0, 0);          // borrow out
    apply(21, 16'h0000, 0, 0, 0);          // chained borrow consumed
    // R4: carry out and overflow
    apply(7, 16'hFFFF, 0, 0, 0);
    apply(20, 16'h0001, 0, 0, 0);
    apply(7, 16'h7FFF, 0, 0, 0);
    apply(19, 0, 16'h0001, 0, 0);
    // R6/R7: strip signs, fix after
    apply(7, 16'hFFFB, 0, 0, 0);
    apply(2, 16'h0003, 0, 0, 0);
    apply(14, 0, 0, 0, 0);
    apply(15, 0, 0, 0, 0);
    apply(14, 0, 0, 0, 0);
    apply(15, 0, 0, 0, 0);
    // R8/R9/R10
    apply(7, 16'hC001, 0, 0, 0);
    apply(2, 16'h8003, 0, 0, 0);
    apply(16, 0, 0, 0, 0);
    apply(17, 0, 0, 0, 0);
    apply(18, 0, 0, 0, 0);
    apply(7, 16'h8000, 0, 0, 0);
    apply(22, 0, 0, 0, 0);
    // R11/R12/R13
    apply(29, 0, 0, 0, 16'h0000);
    apply(26, 16'hBEEF, 0, 0, 0);          // carry 0: DX holds
    apply(29, 0, 0, 0, 16'h0100);
    apply(13, 16'h0000, 0, 0, 0);
    apply(25, 0, 0, 0, 0);
    apply(26, 16'hBEEF, 0, 0, 0);          // carry 1: DX loads
    apply(27, 0, 0, 0, 0);
    apply(28, 0, 0, 0, 0);
    apply(30, 0, 0, 0, 0);
    apply(24, 0, 0, 0, 0);

    // random mix of all operations
    for (int i = 0; i < 4000; i++)
      apply(int'($urandom % 32), pick(), pick(), pick(), pick());

    summary();
  end

endmodule